// File: doc/BRIEF.md
# Dual-Product Mixing Accumulator with Cascade

This block is the arithmetic core of a two-channel video mixer. Every clock it takes two pairs of signed 12-bit operands and forms both products. Either product can be negated on its own. The two products are summed with an optional 16-bit cascade word from an upstream stage. That total either starts a fresh 24-bit running sum or is added to the running sum. Rounding to a 16-bit result may be requested on the cycle that starts a sum.

A 16-bit output register normally follows the upper word of the accumulator. When the swap control is held low, the register stops taking new results. It then alternates between the lower and upper words of the last accumulator value it tracked. A tri-state enable drives the output pins or floats them. Operand delay stacks sit upstream of this block, so the operands arrive already aligned.

The output selector is a small state machine with three states:
- `OS_TRACK`: the register follows the accumulator.
- `OS_LOW`: the register shows the low word of the frozen snapshot.
- `OS_HIGH`: the register shows the high word of the frozen snapshot.

Its transitions are:
- track→low: swap goes low.
- low→high: swap stays low.
- high→low: swap stays low.
- any→track: swap is high.

Top module: `mix_mac_core`

## Requirements
- R1: After reset the output register holds zero, the selector is in `OS_TRACK`, and all pipeline and accumulator state is zero.
- R2: Operands are two's complement. With swap high, accumulate low, rounding off and cascade disabled, the operands applied in cycle t give `out_s` = bits 23:8 of (a*b + c*d). The value appears after the fourth rising edge following cycle t.
- R3: `neg_ab` high subtracts a*b instead of adding it, and `neg_cd` high does the same for c*d. The two controls act independently.
- R4: `acc_en` low loads the accumulator with the new total, discarding the old sum. `acc_en` high adds the new total to the accumulator, which wraps modulo 2^24.
- R5: `rnd_en` high adds 128 (2^7) to the total, but only in a cycle where `acc_en` is low. When `acc_en` is high, `rnd_en` has no effect.
- R6: `cas_off` low registers `cas_in`, sign-extends it, shifts it left by 8 and adds it to the total. `cas_off` high makes the cascade term zero for that cycle's sample.
- R7: With `cas_bypass` high, the cascade word sampled with the operands of cycle t joins the products of cycle t. With it low, the word sampled in cycle t-3 joins instead.
- R8: While `swap_hi` is high, every edge loads the output register with bits 23:8 of the accumulator, as it stood before that edge.
- R9: While `swap_hi` is low, no new result enters the output register. The first edge loads bits 15:0 of the last tracked accumulator value. Each later edge alternates between bits 23:8 and bits 15:0 of that same value.
- R10: `oe_n` high puts every bit of `out_s` in high impedance. `oe_n` low drives the output register onto `out_s`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| a_in | input | 12 | Operand A, signed |
| b_in | input | 12 | Operand B, signed |
| c_in | input | 12 | Operand C, signed |
| d_in | input | 12 | Operand D, signed |
| neg_ab | input | 1 | Subtract product A*B |
| neg_cd | input | 1 | Subtract product C*D |
| acc_en | input | 1 | 1 = add to the running sum, 0 = start a new sum |
| rnd_en | input | 1 | Round on the first cycle of a sum |
| cas_in | input | 16 | Signed cascade word from the upstream stage |
| cas_off | input | 1 | 1 = ignore the cascade word |
| cas_bypass | input | 1 | 1 = skip the three-cycle cascade alignment |
| swap_hi | input | 1 | 1 = track the upper word, 0 = freeze and alternate |
| oe_n | input | 1 | Active-low output enable |
| out_s | output | 16 | Result word, tri-stated |

## Verification
The assertions assume every control input is a clean 0 or 1, held stable around the rising edge. They also assume reset is applied synchronously for at least one edge before any result is relied on. The bench changes every input only on the falling edge. Each input is driven to a defined value from time zero, so each edge samples settled controls. The random phase draws all controls independently, and it biases swap high so that frozen windows stay short while still spanning many transitions.

// File: rtl/mix_pkg.sv
package mix_pkg;

    typedef enum logic [1:0] {
        OS_TRACK = 2'd0,
        OS_LOW   = 2'd1,
        OS_HIGH  = 2'd2
    } osel_e;

endpackage

// File: rtl/mix_prod_stage.sv
module mix_prod_stage #(
    parameter int OPW  = 12,
    parameter int ACCW = 24
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic signed [OPW-1:0]  a_in,
    input  logic signed [OPW-1:0]  b_in,
    input  logic signed [OPW-1:0]  c_in,
    input  logic signed [OPW-1:0]  d_in,
    input  logic                   neg_ab,
    input  logic                   neg_cd,
    output logic signed [ACCW-1:0] p_ab,
    output logic signed [ACCW-1:0] p_cd
);

    localparam int LANES = 2;

    logic signed [OPW-1:0]  x_op [LANES];
    logic signed [OPW-1:0]  y_op [LANES];
    logic                   ng   [LANES];
    logic signed [ACCW-1:0] pq   [LANES];

    assign x_op[0] = a_in;
    assign y_op[0] = b_in;
    assign ng[0]   = neg_ab;
    assign x_op[1] = c_in;
    assign y_op[1] = d_in;
    assign ng[1]   = neg_cd;

    for (genvar gi = 0; gi < LANES; gi++) begin : g_lane
        logic signed [ACCW-1:0] prod;
        logic signed [ACCW-1:0] xe;
        logic signed [ACCW-1:0] ye;

        always_comb begin
            xe   = ACCW'(x_op[gi]);
            ye   = ACCW'(y_op[gi]);
            prod = xe * ye;
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pq[gi] <= '0;
            end else begin
                pq[gi] <= ng[gi] ? -prod : prod;
            end
        end
    end

    assign p_ab = pq[0];
    assign p_cd = pq[1];

    // R3
    neg_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(a_in) == '0) |-> (pq[0] == '0));

endmodule

// File: rtl/mix_cas_align.sv
module mix_cas_align #(
    parameter int CASW = 16,
    parameter int DLY  = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [CASW-1:0] cas_in,
    input  logic            cas_off,
    input  logic            cas_bypass,
    output logic [CASW-1:0] cas_sel
);

    logic [CASW-1:0] cap_q;
    logic            byp_q;
    logic [CASW-1:0] dly_q [DLY];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q <= '0;
            byp_q <= 1'b0;
        end else begin
            cap_q <= cas_off ? '0 : cas_in;
            byp_q <= cas_bypass;
        end
    end

    for (genvar gi = 0; gi < DLY; gi++) begin : g_dly
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                dly_q[gi] <= '0;
            end else if (gi == 0) begin
                dly_q[gi] <= cap_q;
            end else begin
                dly_q[gi] <= dly_q[(gi > 0) ? gi - 1 : 0];
            end
        end
    end

    assign cas_sel = byp_q ? cap_q : dly_q[DLY-1];

    // R6
    cas_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cas_off |=> (cap_q == '0));

    // R7
    cas_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (dly_q[0] == $past(cap_q)));

endmodule

// File: rtl/mix_sum_acc.sv
module mix_sum_acc #(
    parameter int ACCW = 24,
    parameter int OUTW = 16,
    parameter int CASW = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic signed [ACCW-1:0] p_ab,
    input  logic signed [ACCW-1:0] p_cd,
    input  logic [CASW-1:0]        cas_sel,
    input  logic                   acc_en,
    input  logic                   rnd_en,
    output logic signed [ACCW-1:0] acc_q
);

    localparam int CSH = ACCW - OUTW;
    localparam logic [ACCW-1:0] RND_ADD = ACCW'(1) << (ACCW - OUTW - 1);

    logic                   acc_f1;
    logic                   rnd_f1;
    logic                   acc_f2;
    logic signed [ACCW-1:0] sum_q;
    logic signed [ACCW-1:0] cas_ext;
    logic signed [ACCW-1:0] rnd_term;
    logic signed [ACCW-1:0] sum_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_f1 <= 1'b0;
            rnd_f1 <= 1'b0;
        end else begin
            acc_f1 <= acc_en;
            rnd_f1 <= rnd_en;
        end
    end

    always_comb begin
        cas_ext  = ACCW'($signed(cas_sel)) <<< CSH;
        rnd_term = (rnd_f1 && !acc_f1) ? $signed(RND_ADD) : '0;
        sum_d    = p_ab + p_cd + cas_ext + rnd_term;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum_q  <= '0;
            acc_f2 <= 1'b0;
        end else begin
            sum_q  <= sum_d;
            acc_f2 <= acc_f1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (acc_f2) begin
            acc_q <= acc_q + sum_q;
        end else begin
            acc_q <= sum_q;
        end
    end

    // R4
    acc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_f2 |=> (acc_q == $past(sum_q)));

endmodule

// File: rtl/mix_out_sel.sv
module mix_out_sel
    import mix_pkg::*;
#(
    parameter int ACCW = 24,
    parameter int OUTW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [ACCW-1:0] acc_q,
    input  logic            swap_hi,
    output logic [OUTW-1:0] out_q
);

    osel_e           state_q;
    osel_e           state_d;
    logic [ACCW-1:0] snap_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= OS_TRACK;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        unique case (state_q)
            OS_TRACK: state_d = swap_hi ? OS_TRACK : OS_LOW;
            OS_LOW:   state_d = swap_hi ? OS_TRACK : OS_HIGH;
            OS_HIGH:  state_d = swap_hi ? OS_TRACK : OS_LOW;
            default:  state_d = OS_TRACK;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q  <= '0;
            snap_q <= '0;
        end else begin
            unique case (state_d)
                OS_TRACK: begin
                    out_q  <= acc_q[ACCW-1 -: OUTW];
                    snap_q <= acc_q;
                end
                OS_LOW:   out_q <= snap_q[OUTW-1:0];
                OS_HIGH:  out_q <= snap_q[ACCW-1 -: OUTW];
                default:  out_q <= '0;
            endcase
        end
    end

    // R9
    snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !swap_hi |=> $stable(snap_q));

    // R9
    alt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == OS_LOW && !swap_hi) |=> (state_q == OS_HIGH));

endmodule

// File: rtl/mix_mac_core.sv
module mix_mac_core #(
    parameter int OPW  = 12,
    parameter int ACCW = 24,
    parameter int OUTW = 16,
    parameter int CASW = 16,
    parameter int DLY  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OPW-1:0]   a_in,
    input  logic [OPW-1:0]   b_in,
    input  logic [OPW-1:0]   c_in,
    input  logic [OPW-1:0]   d_in,
    input  logic             neg_ab,
    input  logic             neg_cd,
    input  logic             acc_en,
    input  logic             rnd_en,
    input  logic [CASW-1:0]  cas_in,
    input  logic             cas_off,
    input  logic             cas_bypass,
    input  logic             swap_hi,
    input  logic             oe_n,
    output logic [OUTW-1:0]  out_s
);

    logic signed [ACCW-1:0] p_ab;
    logic signed [ACCW-1:0] p_cd;
    logic [CASW-1:0]        cas_sel;
    logic signed [ACCW-1:0] acc_q;
    logic [OUTW-1:0]        out_q;

    mix_prod_stage #(.OPW(OPW), .ACCW(ACCW)) u_prod (
        .clk    (clk),
        .rst_n  (rst_n),
        .a_in   ($signed(a_in)),
        .b_in   ($signed(b_in)),
        .c_in   ($signed(c_in)),
        .d_in   ($signed(d_in)),
        .neg_ab (neg_ab),
        .neg_cd (neg_cd),
        .p_ab   (p_ab),
        .p_cd   (p_cd)
    );

    mix_cas_align #(.CASW(CASW), .DLY(DLY)) u_cas (
        .clk        (clk),
        .rst_n      (rst_n),
        .cas_in     (cas_in),
        .cas_off    (cas_off),
        .cas_bypass (cas_bypass),
        .cas_sel    (cas_sel)
    );

    mix_sum_acc #(.ACCW(ACCW), .OUTW(OUTW), .CASW(CASW)) u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .p_ab    (p_ab),
        .p_cd    (p_cd),
        .cas_sel (cas_sel),
        .acc_en  (acc_en),
        .rnd_en  (rnd_en),
        .acc_q   (acc_q)
    );

    mix_out_sel #(.ACCW(ACCW), .OUTW(OUTW)) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .acc_q   (acc_q),
        .swap_hi (swap_hi),
        .out_q   (out_q)
    );

    assign out_s = oe_n ? {OUTW{1'bz}} : out_q;

    // R8
    out_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        swap_hi |=> (out_q == $past(acc_q[ACCW-1 -: OUTW])));

endmodule

// File: tb/mix_mac_core_test.sv
module mix_mac_core_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] a_in = '0, b_in = '0, c_in = '0, d_in = '0;
    logic        neg_ab = 1'b0, neg_cd = 1'b0, acc_en = 1'b0, rnd_en = 1'b0;
    logic [15:0] cas_in = '0;
    logic        cas_off = 1'b1, cas_bypass = 1'b1, swap_hi = 1'b1, oe_n = 1'b0;
    wire  [15:0] out_s;

    int    n_chk = 0;
    int    n_fail = 0;
    string tag = "R1";
    bit    done = 1'b0;

    always #4 clk = ~clk;

    mix_mac_core uut (
        .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in), .c_in(c_in),
        .d_in(d_in), .neg_ab(neg_ab), .neg_cd(neg_cd), .acc_en(acc_en),
        .rnd_en(rnd_en), .cas_in(cas_in), .cas_off(cas_off),
        .cas_bypass(cas_bypass), .swap_hi(swap_hi), .oe_n(oe_n), .out_s(out_s)
    );

    // reference model state
    logic [23:0] m_p1, m_p2, m_sum, m_acc, m_snap;
    logic [15:0] m_cap, m_d1, m_d2, m_d3, m_out;
    logic        m_accf, m_rndf, m_ftf, m_accf2;
    int          m_st;

    function automatic logic [23:0] prod_of(logic [11:0] x, logic [11:0] y, logic ng);
        logic signed [23:0] p;
        p = 24'($signed(x)) * 24'($signed(y));
        return ng ? -p : p;
    endfunction

    function automatic logic [23:0] total_of(logic [23:0] p1, logic [23:0] p2,
                                             logic [15:0] cv, logic rnd, logic acc);
        logic [23:0] ce;
        ce = {cv, 8'h00};
        return p1 + p2 + ce + ((rnd && !acc) ? 24'd128 : 24'd0);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_p1 = '0; m_p2 = '0; m_sum = '0; m_acc = '0; m_snap = '0;
            m_cap = '0; m_d1 = '0; m_d2 = '0; m_d3 = '0; m_out = '0;
            m_accf = 0; m_rndf = 0; m_ftf = 0; m_accf2 = 0; m_st = 0;
        end else begin
            if (swap_hi) begin
                m_out = m_acc[23:8]; m_snap = m_acc; m_st = 0;
            end else if (m_st == 1) begin
                m_out = m_snap[23:8]; m_st = 2;
            end else begin
                m_out = m_snap[15:0]; m_st = 1;
            end
            m_acc   = m_accf2 ? m_acc + m_sum : m_sum;
            m_sum   = total_of(m_p1, m_p2, m_ftf ? m_cap : m_d3, m_rndf, m_accf);
            m_accf2 = m_accf;
            m_d3 = m_d2; m_d2 = m_d1; m_d1 = m_cap;
            m_cap   = cas_off ? 16'h0 : cas_in;
            m_ftf   = cas_bypass;
            m_accf  = acc_en;
            m_rndf  = rnd_en;
            m_p1    = prod_of(a_in, b_in, neg_ab);
            m_p2    = prod_of(c_in, d_in, neg_cd);
        end
    end

    task automatic check_val(string t, logic [15:0] exp);
        n_chk++;
        if (out_s !== exp) begin
            n_fail++;
            $display("FAIL %s out_s=%h expected=%h", t, out_s, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        if (oe_n) check_val(tag, 16'hzzzz);
        else      check_val(tag, m_out);
    endtask

    task automatic set_ops(int a, int b, int c, int d);
        a_in = 12'(a); b_in = 12'(b); c_in = 12'(c); d_in = 12'(d);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = $urandom(1457);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        tag = "R1";
        @(negedge clk);
        check_val("R1", 16'h0000);

        // R2 hand-computed: 100*200 + (-50)*30 = 18500 -> upper word 72
        tag = "R2";
        set_ops(100, 200, -50, 30);
        repeat (5) step();
        check_val("R2", 16'd72);

        // R3 negate each product
        tag = "R3";
        neg_ab = 1; repeat (5) step();
        check_val("R3", 16'(-((20000 + 1500) >>> 8) - 1));
        neg_ab = 0; neg_cd = 1; repeat (5) step();
        check_val("R3", 16'((20000 + 1500) >> 8));
        neg_cd = 0;

        // R5 rounding: 1*128 gives 128; with round 256 -> 1
        tag = "R5";
        set_ops(1, 128, 0, 0);
        repeat (5) step();
        check_val("R5", 16'd0);
        rnd_en = 1; repeat (5) step();
        check_val("R5", 16'd1);
        acc_en = 1; repeat (6) step();   // R5 rnd ignored while accumulating
        acc_en = 0; rnd_en = 0;

        // R4 accumulate run then clear
        tag = "R4";
        set_ops(2047, 2047, -2048, -2048);
        acc_en = 1; repeat (12) step();
        acc_en = 0; repeat (5) step();

        // R6 cascade enable with bypass
        tag = "R6";
        set_ops(0, 0, 0, 0);
        cas_off = 0; cas_bypass = 1;
        for (int i = 0; i < 8; i++) begin
            cas_in = 16'(16'h1234 + i * 16'h0101);
            cas_off = (i == 4);
            step();
        end
        cas_in = 16'h8001; repeat (5) step();
        check_val("R6", 16'h8001);

        // R7 alignment delay
        tag = "R7";
        cas_bypass = 0;
        for (int i = 0; i < 10; i++) begin
            cas_in = 16'(i * 16'h0111);
            step();
        end
        cas_in = 16'h0000; repeat (8) step();
        cas_off = 1; cas_bypass = 1;

        // R8 / R9 swap patterns
        tag = "R9";
        set_ops(-1234, 321, 777, -5);
        acc_en = 1;
        repeat (4) step();
        swap_hi = 0; repeat (5) step();
        swap_hi = 1; step();
        tag = "R8";
        repeat (3) step();
        swap_hi = 0; step(); swap_hi = 1; step(); swap_hi = 0; repeat (2) step();
        swap_hi = 1; acc_en = 0; repeat (5) step();

        // R10 output enable
        tag = "R10";
        oe_n = 1; repeat (3) step();
        oe_n = 0; repeat (2) step();

        // mixed random stimulus
        tag = "R2";
        for (int i = 0; i < 600; i++) begin
            set_ops(int'($urandom), int'($urandom), int'($urandom), int'($urandom));
            neg_ab     = 1'($urandom);
            neg_cd     = 1'($urandom);
            acc_en     = ($urandom % 3) != 0;
            rnd_en     = 1'($urandom);
            cas_in     = 16'($urandom);
            cas_off    = 1'($urandom);
            cas_bypass = 1'($urandom);
            swap_hi    = ($urandom % 4) != 0;
            oe_n       = ($urandom % 8) == 0;
            step();
        end

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule